// File: doc/BRIEF.md
# Fetch Stall and Redirect Control with Epoch Tagging

This block steers the front end of a two-stage pipeline. Every cycle the fetch side chooses the next program counter. It decides whether the decoded instruction may be dispatched toward execute, and it keeps a one-bit fetch epoch. A hazard stall or a busy downstream queue freezes the program counter, so the same instruction is presented again on the next cycle. Each dispatched instruction is tagged with the fetch epoch. In that same cycle the block strobes a scoreboard insert carrying the instruction's destination register.

The execute side keeps its own epoch bit and compares it with the tag of the instruction at its head. A matching instruction may commit its effects. A mismatched one is on a wrong path and is killed. In both cases its scoreboard entry is released. When a committing instruction reports a mispredict, the execute side toggles its epoch and records the correct target in a one-entry redirect slot. The fetch side consumes that slot on the next cycle, ahead of any dispatch. It loads the target and toggles the fetch epoch, so younger wrong-path instructions can be told apart by their tag.

Top module: `fetch_stall_ctrl`

## Requirements
- R1: After reset the program counter equals parameter RESET_PC (default 0), the fetch epoch and execute epoch are both 0, and no redirect is pending (`redir_take` low).
- R2: While a redirect is pending, `redir_take` is high and nothing is dispatched or inserted. On the following edge the program counter takes the redirect target, the fetch epoch inverts and the slot empties.
- R3: With no redirect pending, dispatch is blocked when a source whose valid flag is 1 has its scoreboard hit at 1, or when the destination valid flag is 1 and its hit is 1. A hit whose valid flag is 0 has no effect.
- R4: The program counter moves to `pred_npc` only on an edge at which `disp_vld` was high. On any other edge without a redirect it keeps its value.
- R5: With `disp_rdy` low, nothing is dispatched and the program counter holds, as for a hazard stall.
- R6: A dispatch presents `disp_pc` equal to the current program counter, `disp_npc` equal to `pred_npc` and `disp_epoch` equal to the fetch epoch. `sb_ins` is high in exactly the dispatch cycles, carrying `dst_idx` and `dst_vld`.
- R7: When `ex_vld` is high, `ex_commit` is high if `ex_epoch` equals the execute epoch and `ex_kill` is high otherwise. `sb_remove` is high whenever `ex_vld` is high.
- R8: A mispredict on a committing instruction makes a redirect to `ex_target` pending from the next cycle and inverts the execute epoch. A mispredict on a killed instruction changes neither.
- R9: A mispredict that commits in the same cycle as a redirect is consumed leaves the new target pending, and it is taken on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inst_vld | input | 1 | A decoded instruction is present at fetch |
| src_a_vld | input | 1 | First source register is used |
| src_a_hit | input | 1 | Scoreboard match on first source |
| src_b_vld | input | 1 | Second source register is used |
| src_b_hit | input | 1 | Scoreboard match on second source |
| dst_vld | input | 1 | Destination register is written |
| dst_idx | input | IDX_W | Destination register index |
| dst_hit | input | 1 | Scoreboard match on destination (write-after-write) |
| pred_npc | input | ADDR_W | Predicted next address |
| disp_rdy | input | 1 | Dispatch queue can accept |
| pc | output | ADDR_W | Current program counter |
| fetch_epoch | output | 1 | Fetch epoch bit |
| disp_vld | output | 1 | Instruction dispatched this cycle |
| disp_pc | output | ADDR_W | Address of dispatched instruction |
| disp_npc | output | ADDR_W | Predicted next address sent with it |
| disp_epoch | output | 1 | Epoch tag of dispatched instruction |
| sb_ins | output | 1 | Scoreboard insert strobe |
| sb_ins_dst | output | IDX_W | Destination index inserted |
| sb_ins_dst_vld | output | 1 | Inserted destination is valid |
| redir_take | output | 1 | Pending redirect consumed this cycle |
| ex_vld | input | 1 | Instruction at the execute head |
| ex_epoch | input | 1 | Epoch tag of that instruction |
| ex_mispredict | input | 1 | That instruction found a mispredict |
| ex_target | input | ADDR_W | Correct target for the mispredict |
| exec_epoch | output | 1 | Execute epoch bit |
| ex_commit | output | 1 | Instruction may perform side effects |
| ex_kill | output | 1 | Instruction is wrong-path and discarded |
| sb_remove | output | 1 | Scoreboard remove strobe |

## Verification
Two functions can fall in one cycle: consuming a pending redirect at fetch, and committing a fresh mispredict at execute. The bench raises a mispredict, then on the next cycle, while the first redirect is being taken, raises a second matching mispredict with a different target. It judges the result by the program counter landing on the first target, then on the second one a cycle later, with the fetch epoch inverting on both edges. A ready, hazard-free instruction is also held at fetch during each redirect cycle, to show that the redirect wins over dispatch.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    // What the fetch side does in a cycle; redirect outranks everything.
    typedef enum logic [1:0] {
        FA_HOLD     = 2'd0,
        FA_DISPATCH = 2'd1,
        FA_REDIRECT = 2'd2
    } fetch_act_e;

    // A scoreboard hit counts only when the register field is in use.
    function automatic logic qualified_hit(input logic used, input logic hit);
        return used & hit;
    endfunction

endpackage

// File: rtl/fsc_hazard.sv
module fsc_hazard #(
    parameter int NCHK = 3
) (
    input  logic [NCHK-1:0] fld_vld,
    input  logic [NCHK-1:0] fld_hit,
    output logic            stall
);
    import fsc_pkg::*;

    logic [NCHK-1:0] hit_q;

    generate
        for (genvar i = 0; i < NCHK; i++) begin : g_chk
            assign hit_q[i] = qualified_hit(fld_vld[i], fld_hit[i]);
        end
    endgenerate

    assign stall = |hit_q;
endmodule

// File: rtl/fsc_fetch.sv
module fsc_fetch #(
    parameter int              ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inst_vld,
    input  logic              stall,
    input  logic              disp_rdy,
    input  logic [ADDR_W-1:0] pred_npc,
    input  logic              redir_pend,
    input  logic [ADDR_W-1:0] redir_tgt,
    output logic [ADDR_W-1:0] pc,
    output logic              epoch,
    output logic              fire,
    output logic              take
);
    import fsc_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic              epoch;
    } fstate_t;

    fstate_t    st_d, st_q;
    fetch_act_e act_d;

    always_comb begin
        st_d = st_q;
        if (redir_pend) begin
            act_d = FA_REDIRECT;
        end else if (inst_vld && !stall && disp_rdy) begin
            act_d = FA_DISPATCH;
        end else begin
            act_d = FA_HOLD;
        end

        case (act_d)
            FA_REDIRECT: begin
                st_d.pc    = redir_tgt;
                st_d.epoch = ~st_q.epoch;
            end
            FA_DISPATCH: st_d.pc = pred_npc;
            default:     st_d    = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pc    <= RESET_PC;
            st_q.epoch <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc    = st_q.pc;
    assign epoch = st_q.epoch;
    assign fire  = (act_d == FA_DISPATCH);
    assign take  = (act_d == FA_REDIRECT);
endmodule

// File: rtl/fsc_exec.sv
module fsc_exec #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ex_vld,
    input  logic              ex_epoch,
    input  logic              ex_mispredict,
    input  logic [ADDR_W-1:0] ex_target,
    input  logic              take,
    output logic              epoch,
    output logic              redir_pend,
    output logic [ADDR_W-1:0] redir_tgt,
    output logic              commit,
    output logic              kill,
    output logic              remove
);
    typedef struct packed {
        logic              epoch;
        logic              pend;
        logic [ADDR_W-1:0] tgt;
    } estate_t;

    estate_t st_d, st_q;
    logic    match;

    always_comb begin
        st_d   = st_q;
        match  = (ex_epoch == st_q.epoch);
        commit = ex_vld && match;
        kill   = ex_vld && !match;
        remove = ex_vld;

        // Consumption first, so a fresh redirect in the same cycle survives.
        if (take) begin
            st_d.pend = 1'b0;
        end
        if (commit && ex_mispredict) begin
            st_d.pend  = 1'b1;
            st_d.tgt   = ex_target;
            st_d.epoch = ~st_q.epoch;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.epoch <= 1'b0;
            st_q.pend  <= 1'b0;
            st_q.tgt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign epoch      = st_q.epoch;
    assign redir_pend = st_q.pend;
    assign redir_tgt  = st_q.tgt;
endmodule

// File: rtl/fetch_stall_ctrl.sv
module fetch_stall_ctrl #(
    parameter int                ADDR_W   = 32,
    parameter int                IDX_W    = 5,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inst_vld,
    input  logic              src_a_vld,
    input  logic              src_a_hit,
    input  logic              src_b_vld,
    input  logic              src_b_hit,
    input  logic              dst_vld,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic              dst_hit,
    input  logic [ADDR_W-1:0] pred_npc,
    input  logic              disp_rdy,
    output logic [ADDR_W-1:0] pc,
    output logic              fetch_epoch,
    output logic              disp_vld,
    output logic [ADDR_W-1:0] disp_pc,
    output logic [ADDR_W-1:0] disp_npc,
    output logic              disp_epoch,
    output logic              sb_ins,
    output logic [IDX_W-1:0]  sb_ins_dst,
    output logic              sb_ins_dst_vld,
    output logic              redir_take,
    input  logic              ex_vld,
    input  logic              ex_epoch,
    input  logic              ex_mispredict,
    input  logic [ADDR_W-1:0] ex_target,
    output logic              exec_epoch,
    output logic              ex_commit,
    output logic              ex_kill,
    output logic              sb_remove
);
    localparam int NCHK = 3;

    logic              stall;
    logic              fire;
    logic              pend;
    logic [ADDR_W-1:0] tgt;

    fsc_hazard #(.NCHK(NCHK)) i_hazard (
        .fld_vld ({dst_vld, src_b_vld, src_a_vld}),
        .fld_hit ({dst_hit, src_b_hit, src_a_hit}),
        .stall   (stall)
    );

    fsc_fetch #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) i_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .inst_vld   (inst_vld),
        .stall      (stall),
        .disp_rdy   (disp_rdy),
        .pred_npc   (pred_npc),
        .redir_pend (pend),
        .redir_tgt  (tgt),
        .pc         (pc),
        .epoch      (fetch_epoch),
        .fire       (fire),
        .take       (redir_take)
    );

    fsc_exec #(.ADDR_W(ADDR_W)) i_exec (
        .clk           (clk),
        .rst_n         (rst_n),
        .ex_vld        (ex_vld),
        .ex_epoch      (ex_epoch),
        .ex_mispredict (ex_mispredict),
        .ex_target     (ex_target),
        .take          (redir_take),
        .epoch         (exec_epoch),
        .redir_pend    (pend),
        .redir_tgt     (tgt),
        .commit        (ex_commit),
        .kill          (ex_kill),
        .remove        (sb_remove)
    );

    assign disp_vld       = fire;
    assign disp_pc        = pc;
    assign disp_npc       = pred_npc;
    assign disp_epoch     = fetch_epoch;
    assign sb_ins         = fire;
    assign sb_ins_dst     = dst_idx;
    assign sb_ins_dst_vld = dst_vld;
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              src_a_vld,
    input logic              src_a_hit,
    input logic              src_b_vld,
    input logic              src_b_hit,
    input logic              dst_vld,
    input logic              dst_hit,
    input logic              disp_rdy,
    input logic [ADDR_W-1:0] pc,
    input logic              fetch_epoch,
    input logic              disp_vld,
    input logic [ADDR_W-1:0] disp_npc,
    input logic              redir_take,
    input logic              ex_vld,
    input logic              ex_mispredict,
    input logic              exec_epoch,
    input logic              ex_commit,
    input logic              ex_kill,
    input logic              sb_remove
);
    assert_redir_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        redir_take |-> !disp_vld);

    assert_redir_flips_R2: assert property (@(posedge clk) disable iff (!rst_n)
        redir_take |=> fetch_epoch != $past(fetch_epoch));

    assert_hazard_R3: assert property (@(posedge clk) disable iff (!rst_n)
        disp_vld |-> !((src_a_vld && src_a_hit) || (src_b_vld && src_b_hit) || (dst_vld && dst_hit)));

    assert_pc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_vld && !redir_take) |=> pc == $past(pc));

    assert_pc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        disp_vld |=> pc == $past(disp_npc));

    assert_not_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_rdy |-> !disp_vld);

    assert_kill_or_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ex_vld |-> (ex_commit != ex_kill) && sb_remove);

    assert_mispredict_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_commit && ex_mispredict) |=> redir_take && (exec_epoch != $past(exec_epoch)));

    assert_killed_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ex_kill |=> exec_epoch == $past(exec_epoch));
endmodule

bind fetch_stall_ctrl fsc_checker #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_fetch_stall_ctrl.sv
module test_fetch_stall_ctrl;
    localparam int AW = 32;
    localparam int IW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          inst_vld, src_a_vld, src_a_hit, src_b_vld, src_b_hit;
    logic          dst_vld, dst_hit, disp_rdy;
    logic [IW-1:0] dst_idx;
    logic [AW-1:0] pred_npc;
    logic [AW-1:0] pc, disp_pc, disp_npc;
    logic          fetch_epoch, disp_vld, disp_epoch, sb_ins, sb_ins_dst_vld, redir_take;
    logic [IW-1:0] sb_ins_dst;
    logic          ex_vld, ex_epoch, ex_mispredict;
    logic [AW-1:0] ex_target;
    logic          exec_epoch, ex_commit, ex_kill, sb_remove;

    int checks   = 0;
    int failures = 0;

    always #10 clk = ~clk;

    fetch_stall_ctrl #(.ADDR_W(AW), .IDX_W(IW)) i_fetch_stall_ctrl (.*);

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        inst_vld = 0; src_a_vld = 0; src_a_hit = 0; src_b_vld = 0; src_b_hit = 0;
        dst_vld = 0; dst_hit = 0; dst_idx = '0; pred_npc = '0; disp_rdy = 1;
        ex_vld = 0; ex_epoch = 0; ex_mispredict = 0; ex_target = '0;
    endtask

    task automatic t_reset();
        chk("R1 pc", pc, 0);
        chk("R1 fetch_epoch", {31'd0, fetch_epoch}, 0);
        chk("R1 exec_epoch", {31'd0, exec_epoch}, 0);
        chk("R1 redir_take", {31'd0, redir_take}, 0);
    endtask

    task automatic t_dispatch();
        inst_vld = 1; pred_npc = 32'h10; dst_vld = 1; dst_idx = 5'd7; #1;
        chk("R6 disp_vld", {31'd0, disp_vld}, 1);
        chk("R6 disp_pc", disp_pc, 0);
        chk("R6 disp_npc", disp_npc, 32'h10);
        chk("R6 disp_epoch", {31'd0, disp_epoch}, 0);
        chk("R6 sb_ins", {31'd0, sb_ins}, 1);
        chk("R6 sb_ins_dst", {27'd0, sb_ins_dst}, 7);
        chk("R6 sb_ins_dst_vld", {31'd0, sb_ins_dst_vld}, 1);
        step();
        chk("R4 pc advance", pc, 32'h10);
    endtask

    task automatic t_stall();
        pred_npc = 32'h20; src_a_vld = 1; src_a_hit = 1; #1;
        chk("R3 src_a stall disp", {31'd0, disp_vld}, 0);
        chk("R6 no insert on stall", {31'd0, sb_ins}, 0);
        step();
        chk("R4 pc hold", pc, 32'h10);
        src_a_vld = 0; src_b_vld = 1; src_b_hit = 1; #1;
        chk("R3 src_b stall", {31'd0, disp_vld}, 0);
        step();
        src_b_vld = 0; dst_hit = 1; #1;
        chk("R3 dst stall", {31'd0, disp_vld}, 0);
        step();
        chk("R4 pc hold dst", pc, 32'h10);
        // hits without valid flags are ignored
        dst_vld = 0; src_a_hit = 1; #1;
        chk("R3 unqualified hits ignored", {31'd0, disp_vld}, 1);
        step();
        chk("R3 pc after ignored hits", pc, 32'h20);
        src_a_hit = 0; src_b_hit = 0; dst_hit = 0;
    endtask

    task automatic t_not_ready();
        pred_npc = 32'h30; disp_rdy = 0; #1;
        chk("R5 no dispatch", {31'd0, disp_vld}, 0);
        step();
        chk("R5 pc hold", pc, 32'h20);
        disp_rdy = 1;
    endtask

    task automatic t_mispredict();
        pred_npc = 32'h24;
        ex_vld = 1; ex_epoch = 0; ex_mispredict = 1; ex_target = 32'h200; #1;
        chk("R7 commit", {31'd0, ex_commit}, 1);
        chk("R7 no kill", {31'd0, ex_kill}, 0);
        chk("R7 remove", {31'd0, sb_remove}, 1);
        step();   // dispatch of pc 0x20 happened on this edge
        idle(); inst_vld = 1; pred_npc = 32'h28; #1;
        chk("R8 exec_epoch toggled", {31'd0, exec_epoch}, 1);
        chk("R8 redirect pending", {31'd0, redir_take}, 1);
        chk("R2 redirect blocks dispatch", {31'd0, disp_vld}, 0);
        step();
        chk("R2 pc loaded", pc, 32'h200);
        chk("R2 fetch_epoch toggled", {31'd0, fetch_epoch}, 1);
        chk("R2 slot emptied", {31'd0, redir_take}, 0);
    endtask

    task automatic t_kill();
        inst_vld = 0;
        ex_vld = 1; ex_epoch = 0; ex_mispredict = 1; ex_target = 32'h999; #1;
        chk("R7 kill", {31'd0, ex_kill}, 1);
        chk("R7 no commit", {31'd0, ex_commit}, 0);
        chk("R7 remove on kill", {31'd0, sb_remove}, 1);
        step();
        idle(); inst_vld = 0; #1;
        chk("R8 killed mispredict no redirect", {31'd0, redir_take}, 0);
        chk("R8 killed mispredict epoch", {31'd0, exec_epoch}, 1);
        step();
        chk("R8 pc unaffected", pc, 32'h200);
    endtask

    task automatic t_collide();
        ex_vld = 1; ex_epoch = 1; ex_mispredict = 1; ex_target = 32'h300; #1;
        step();
        // first redirect is consumed while a second mispredict commits
        inst_vld = 1; pred_npc = 32'h204;
        ex_vld = 1; ex_epoch = 0; ex_mispredict = 1; ex_target = 32'h400; #1;
        chk("R9 first redirect taken", {31'd0, redir_take}, 1);
        chk("R9 second commit", {31'd0, ex_commit}, 1);
        step();
        ex_vld = 0; ex_mispredict = 0; #1;
        chk("R9 pc first target", pc, 32'h300);
        chk("R9 epoch after first", {31'd0, fetch_epoch}, 0);
        chk("R9 second redirect pending", {31'd0, redir_take}, 1);
        step();
        chk("R9 pc second target", pc, 32'h400);
        chk("R9 epoch after second", {31'd0, fetch_epoch}, 1);
    endtask

    initial begin
        idle();
        rst_n = 0;
        step(); step();
        rst_n = 1; #1;
        t_reset();
        t_dispatch();
        t_stall();
        t_not_ready();
        t_mispredict();
        t_kill();
        t_collide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 20000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule